// File: doc/BRIEF.md
# Branch Target Buffer with Target-Instruction Folding

This block is a small, fully associative table that the fetch stage searches with the current fetch address. Each valid entry pairs the address of a branch with the place it jumps to. When the fetch address matches an entry, the block returns that stored destination as the next fetch address in the same cycle. The fetch stage can therefore redirect without waiting for decode. On a miss the block returns the sequential address.

Each entry can also hold the instruction word found at the branch destination, together with a flag that marks the branch as unconditional. When a lookup hits such an entry and folding is built in, the block raises a fold indication and presents the stored destination instruction. The fetch stage issues that word in place of the branch, so the branch costs no cycle. Because the destination instruction has already been supplied, the next fetch address is then the destination plus 4.

Decode writes an entry when it finds a taken branch. A write to an address that is already present rewrites that entry. A write to a new address takes the lowest-numbered free entry, or evicts entries in rotating order when the table is full. A separate clear port removes the entry for a branch that turned out not to be taken.

Top module: `btb_fold`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, `foldValid` is 0, `foldInstr` is 0 and `predNextPc` equals `fetchPc + 4`.
- R2: On a miss, `hit` is 0 and `predNextPc` is `fetchPc + 4` modulo 2^AW. For example, 32'hFFFF_FFFC gives 0.
- R3: A lookup that hits an entry whose unconditional flag is 0 gives `hit`=1 and `predNextPc` equal to the stored destination. In the same lookup `foldValid` is 0 and `foldInstr` is 0.
- R4: With FOLD_EN=1, a lookup that hits an entry whose unconditional flag is 1 gives `foldValid`=1 and `foldInstr` equal to the stored destination instruction. In the same lookup `predNextPc` is the stored destination plus 4.
- R5: Lookups are combinational. A write made at a clock edge is visible to lookups from that edge on. A lookup in the same cycle as the write still sees the old contents.
- R6: A write whose branch address matches a valid entry overwrites that entry in place. It takes no second entry and does not move the replacement pointer.
- R7: A write to a new address goes to the lowest-numbered invalid entry whenever one exists. The replacement pointer does not move.
- R8: When all entries are valid, a write to a new address evicts the entry named by a rotating pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such an eviction.
- R9: An asserted `invEn` clears the valid entry whose branch address equals `invPc`. If no entry matches, the table does not change.
- R10: When `updEn` and `invEn` are both asserted in the same cycle, the clear is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | AW | Address being fetched |
| hit | output | 1 | Fetch address matches a valid entry |
| predNextPc | output | AW | Next fetch address |
| foldValid | output | 1 | Issue `foldInstr` in place of the branch |
| foldInstr | output | IW | Instruction at the branch destination (0 when not folding) |
| updEn | input | 1 | Write a taken branch from decode |
| updPc | input | AW | Branch address to write |
| updTarget | input | AW | Branch destination to write |
| updUncond | input | 1 | Branch is unconditional |
| updInstr | input | IW | Instruction word at the destination |
| invEn | input | 1 | Clear the entry for a not-taken branch |
| invPc | input | AW | Branch address to clear |

## Verification
The lookup outputs are combinational in `fetchPc`. The bench applies each address on a falling edge and samples 1 ns later, with no rising edge in between. A write or clear takes effect at the next rising edge, so its effect is checked at the falling edge that follows. One check samples the lookup in the cycle of the write itself, to confirm that the old contents are still seen there. Placement and replacement are checked only through later lookups. After a chosen sequence of writes, the bench probes which branch addresses still hit, and that result exposes which entry each write took.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic wrEn;   // write entry at wrIdx
    logic clrEn;  // clear valid bit at clrIdx
    logic advRr;  // rotating victim pointer moves on
  } btbStrobe_t;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath #(
  parameter int ENTRIES = 4,
  parameter int AW      = 32,
  parameter int IW      = 32,
  parameter bit FOLD_EN = 1'b1,
  parameter int IDXW    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  btb_pkg::btbStrobe_t  strb,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic [IDXW-1:0]      clrIdx,
  input  logic [AW-1:0]        fetchPc,
  input  logic [AW-1:0]        updPc,
  input  logic [AW-1:0]        updTarget,
  input  logic                 updUncond,
  input  logic [IW-1:0]        updInstr,
  input  logic [AW-1:0]        invPc,
  output logic [ENTRIES-1:0]   validVec,
  output logic [ENTRIES-1:0]   updMatch,
  output logic [ENTRIES-1:0]   invMatch,
  output logic                 hit,
  output logic [AW-1:0]        predNextPc,
  output logic                 foldValid,
  output logic [IW-1:0]        foldInstr
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] tagQ    [ENTRIES];
  logic [AW-1:0] tgtQ    [ENTRIES];
  logic          uncondQ [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;
  logic [AW-1:0] lkTgt;
  logic          lkUncond;
  logic          foldSel;

  // valid bits: reset, set on write, cleared on invalidate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      if (strb.wrEn)  validVec[wrIdx]  <= 1'b1;
      if (strb.clrEn) validVec[clrIdx] <= 1'b0;
    end
  end

  // payload storage needs no reset, qualified by valid
  always_ff @(posedge clk) begin
    if (rstN && strb.wrEn) begin
      tagQ[wrIdx]    <= updPc;
      tgtQ[wrIdx]    <= updTarget;
      uncondQ[wrIdx] <= updUncond;
    end
  end

  // three comparator banks: fetch lookup, update and invalidate
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCmp
      assign lkMatch[g]  = validVec[g] && (tagQ[g] == fetchPc);
      assign updMatch[g] = validVec[g] && (tagQ[g] == updPc);
      assign invMatch[g] = validVec[g] && (tagQ[g] == invPc);
    end
  endgenerate

  // one-hot read mux (tags are kept unique)
  always_comb begin
    lkTgt    = '0;
    lkUncond = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) begin
        lkTgt    = lkTgt | tgtQ[i];
        lkUncond = lkUncond | uncondQ[i];
      end
    end
  end

  assign hit = |lkMatch;

  generate
    if (FOLD_EN) begin : gFold
      logic [IW-1:0] instrQ [ENTRIES];
      logic [IW-1:0] lkInstr;
      always_ff @(posedge clk) begin
        if (rstN && strb.wrEn) instrQ[wrIdx] <= updInstr;
      end
      always_comb begin
        lkInstr = '0;
        for (int i = 0; i < ENTRIES; i++)
          if (lkMatch[i]) lkInstr = lkInstr | instrQ[i];
      end
      assign foldSel   = hit && lkUncond;
      assign foldInstr = foldSel ? lkInstr : '0;
    end else begin : gNoFold
      logic unusedFold;
      assign unusedFold = ^{updInstr, lkUncond};
      assign foldSel    = 1'b0;
      assign foldInstr  = '0;
    end
  endgenerate

  assign foldValid  = foldSel;
  assign predNextPc = !hit   ? fetchPc + STEP :
                      foldSel ? lkTgt + STEP  : lkTgt;
endmodule

// File: rtl/btb_control.sv
module btb_control #(
  parameter int ENTRIES = 4,
  parameter int IDXW    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updEn,
  input  logic                 invEn,
  input  logic [ENTRIES-1:0]   validVec,
  input  logic [ENTRIES-1:0]   updMatch,
  input  logic [ENTRIES-1:0]   invMatch,
  output btb_pkg::btbStrobe_t  strb,
  output logic [IDXW-1:0]      wrIdx,
  output logic [IDXW-1:0]      clrIdx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(ENTRIES - 1);

  logic [IDXW-1:0] rrPtr;
  logic [IDXW-1:0] sameIdx, freeIdx;
  logic            anyFree, anySame;

  // lowest index wins in each encoder
  always_comb begin
    sameIdx = '0;
    freeIdx = '0;
    clrIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (updMatch[i])  sameIdx = IDXW'(i);
      if (!validVec[i]) freeIdx = IDXW'(i);
      if (invMatch[i])  clrIdx  = IDXW'(i);
    end
  end

  assign anySame = |updMatch;
  assign anyFree = ~&validVec;

  always_comb begin
    strb.wrEn  = updEn && !invEn;
    strb.clrEn = invEn && (|invMatch);
    strb.advRr = strb.wrEn && !anySame && !anyFree;
    if (anySame)      wrIdx = sameIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rrPtr <= '0;
    else if (strb.advRr) rrPtr <= (rrPtr == LAST) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/btb_fold.sv
module btb_fold #(
  parameter int ENTRIES = 4,
  parameter int AW      = 32,
  parameter int IW      = 32,
  parameter bit FOLD_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] fetchPc,
  output logic          hit,
  output logic [AW-1:0] predNextPc,
  output logic          foldValid,
  output logic [IW-1:0] foldInstr,
  input  logic          updEn,
  input  logic [AW-1:0] updPc,
  input  logic [AW-1:0] updTarget,
  input  logic          updUncond,
  input  logic [IW-1:0] updInstr,
  input  logic          invEn,
  input  logic [AW-1:0] invPc
);
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  btb_pkg::btbStrobe_t strb;
  logic [IDXW-1:0]     wrIdx, clrIdx;
  logic [ENTRIES-1:0]  validVec, updMatch, invMatch;

  btb_control #(.ENTRIES(ENTRIES), .IDXW(IDXW)) uCtl (
    .clk(clk), .rstN(rstN), .updEn(updEn), .invEn(invEn),
    .validVec(validVec), .updMatch(updMatch), .invMatch(invMatch),
    .strb(strb), .wrIdx(wrIdx), .clrIdx(clrIdx)
  );

  btb_datapath #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW), .FOLD_EN(FOLD_EN),
                 .IDXW(IDXW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .clrIdx(clrIdx),
    .fetchPc(fetchPc), .updPc(updPc), .updTarget(updTarget),
    .updUncond(updUncond), .updInstr(updInstr), .invPc(invPc),
    .validVec(validVec), .updMatch(updMatch), .invMatch(invMatch),
    .hit(hit), .predNextPc(predNextPc), .foldValid(foldValid),
    .foldInstr(foldInstr)
  );
endmodule

// File: rtl/btb_fold_chk.sv
module btb_fold_chk #(
  parameter int AW      = 32,
  parameter int IW      = 32,
  parameter bit FOLD_EN = 1'b1
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] fetchPc,
  input logic          hit,
  input logic [AW-1:0] predNextPc,
  input logic          foldValid,
  input logic [IW-1:0] foldInstr,
  input logic          updEn,
  input logic [AW-1:0] updPc,
  input logic [AW-1:0] updTarget,
  input logic          updUncond,
  input logic          invEn,
  input logic [AW-1:0] invPc
);
  // R5
  upd_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && !invEn) |=> (fetchPc != $past(updPc)) || hit);

  // R3
  upd_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && !invEn && !updUncond) |=>
      (fetchPc != $past(updPc)) || (predNextPc == $past(updTarget) && !foldValid));

  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    invEn |=> (fetchPc != $past(invPc)) || !hit);

  // R4
  fold_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    foldValid |-> hit && (FOLD_EN != 1'b0));

  // R2
  miss_no_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> !foldValid && (foldInstr == '0));
endmodule

bind btb_fold btb_fold_chk #(.AW(AW), .IW(IW), .FOLD_EN(FOLD_EN)) uChk (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .hit(hit),
  .predNextPc(predNextPc), .foldValid(foldValid), .foldInstr(foldInstr),
  .updEn(updEn), .updPc(updPc), .updTarget(updTarget),
  .updUncond(updUncond), .invEn(invEn), .invPc(invPc)
);

// File: tb/tb_btb_fold.sv
`timescale 1ns/1ps
module tb_btb_fold;
  localparam int AW = 32;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic          hit, foldValid;
  logic [AW-1:0] predNextPc;
  logic [IW-1:0] foldInstr;
  logic          updEn = 1'b0, updUncond = 1'b0, invEn = 1'b0;
  logic [AW-1:0] updPc = '0, updTarget = '0, invPc = '0;
  logic [IW-1:0] updInstr = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  btb_fold #(.ENTRIES(4), .AW(AW), .IW(IW), .FOLD_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .hit(hit),
    .predNextPc(predNextPc), .foldValid(foldValid), .foldInstr(foldInstr),
    .updEn(updEn), .updPc(updPc), .updTarget(updTarget),
    .updUncond(updUncond), .updInstr(updInstr), .invEn(invEn), .invPc(invPc)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // full lookup check, sampled 1 ns after a falling edge
  task automatic look(string req, logic [AW-1:0] pc, bit expHit,
                      logic [AW-1:0] expNext, bit expFold, logic [IW-1:0] expInstr);
    @(negedge clk);
    fetchPc = pc;
    #1;
    check(req, "hit", hit, expHit);
    check(req, "next pc", predNextPc, expNext);
    check(req, "fold", foldValid, expFold);
    check(req, "fold instr", foldInstr, expInstr);
  endtask

  task automatic probe(string req, logic [AW-1:0] pc, bit expHit);
    @(negedge clk);
    fetchPc = pc;
    #1;
    check(req, $sformatf("hit @%0h", pc), hit, expHit);
  endtask

  task automatic write(logic [AW-1:0] pc, logic [AW-1:0] tgt, bit unc, logic [IW-1:0] ins);
    @(negedge clk);
    updEn = 1'b1; updPc = pc; updTarget = tgt; updUncond = unc; updInstr = ins;
    @(negedge clk);
    updEn = 1'b0;
  endtask

  task automatic clear(logic [AW-1:0] pc);
    @(negedge clk);
    invEn = 1'b1; invPc = pc;
    @(negedge clk);
    invEn = 1'b0;
  endtask

  task automatic testReset();
    look("R1", 32'h100, 1'b0, 32'h104, 1'b0, '0);
    look("R2", 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, '0);
  endtask

  task automatic testCondHit();
    // R5: lookup in the write cycle still misses
    @(negedge clk);
    updEn = 1'b1; updPc = 32'h100; updTarget = 32'h800; updUncond = 1'b0;
    updInstr = 32'h5555_0000; fetchPc = 32'h100;
    #1;
    check("R5", "same-cycle hit", hit, 1'b0);
    @(negedge clk);
    updEn = 1'b0;
    #1;
    check("R5", "next-cycle hit", hit, 1'b1);
    look("R3", 32'h100, 1'b1, 32'h800, 1'b0, '0);
  endtask

  task automatic testFold();
    write(32'h200, 32'hA00, 1'b1, 32'hDEAD_BEEF);
    look("R4", 32'h200, 1'b1, 32'hA04, 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic testOverwrite();
    write(32'h300, 32'hB00, 1'b0, '0);
    write(32'h400, 32'hC00, 1'b0, '0);
    write(32'h100, 32'h900, 1'b1, 32'h1111_2222);   // same address, in place
    look("R6", 32'h100, 1'b1, 32'h904, 1'b1, 32'h1111_2222);
    probe("R6", 32'h200, 1'b1);
    probe("R6", 32'h300, 1'b1);
    probe("R6", 32'h400, 1'b1);
  endtask

  task automatic testRoundRobin();
    write(32'h500, 32'hD00, 1'b0, '0);              // full: evicts entry 0 (0x100)
    probe("R8", 32'h100, 1'b0);
    probe("R8", 32'h500, 1'b1);
    probe("R8", 32'h200, 1'b1);
  endtask

  task automatic testInvalidate();
    clear(32'h777);                                  // no match
    probe("R9", 32'h200, 1'b1);
    probe("R9", 32'h300, 1'b1);
    probe("R9", 32'h400, 1'b1);
    probe("R9", 32'h500, 1'b1);
    clear(32'h400);                                  // frees entry 3
    probe("R9", 32'h400, 1'b0);
    write(32'h600, 32'hE00, 1'b0, '0);              // R7: into entry 3
    write(32'h700, 32'hF00, 1'b0, '0);              // R8: evicts entry 1 (0x200)
    probe("R8", 32'h200, 1'b0);
    probe("R7", 32'h300, 1'b1);
    probe("R7", 32'h500, 1'b1);
    probe("R7", 32'h600, 1'b1);
    probe("R7", 32'h700, 1'b1);
  endtask

  task automatic testInvPriority();
    @(negedge clk);
    updEn = 1'b1; updPc = 32'h880; updTarget = 32'h1000; updUncond = 1'b0;
    invEn = 1'b1; invPc = 32'h300;
    @(negedge clk);
    updEn = 1'b0; invEn = 1'b0;
    probe("R10", 32'h880, 1'b0);
    probe("R10", 32'h300, 1'b0);
    probe("R10", 32'h500, 1'b1);
    write(32'h900, 32'h1100, 1'b0, '0);             // R7: into free entry 2
    write(32'hA80, 32'h1200, 1'b0, '0);             // R8: pointer at 2 evicts 0x900
    probe("R8", 32'h900, 1'b0);
    probe("R8", 32'hA80, 1'b1);
    probe("R7", 32'h500, 1'b1);
    probe("R7", 32'h600, 1'b1);
    probe("R7", 32'h700, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCondHit();
    testFold();
    testOverwrite();
    testRoundRobin();
    testInvalidate();
    testInvPriority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule